// File: doc/BRIEF.md
# Gated Event Timer with Selectable Gate Source

This block is a 16-bit up-counter that advances on clock-enable ticks only while a gate condition holds. The gate is picked by a two-bit selector from three places: an external pin, brought in through a synchronizer, the wrap pulse of an 8-bit free-running timer, or the reload pulse of an 8-bit period timer. Both helper timers live inside the block and run on the same tick.

A polarity input chooses whether the selected gate counts while high or while low. A toggle mode passes the polarity-adjusted gate through a flip-flop that flips on each rising gate edge. The counter then runs across one whole gate period rather than across one level. A bypass input disables gating so that every tick counts. A status output shows the gate that is in effect at any moment. Software may load the counter synchronously, and an overflow flag pulses when the counter wraps.

Top module: `gated_timer`

## Requirements
- R1: After a synchronous active-low reset, the counter, the overflow flag, both helper timers, the synchronizer stages and the toggle flip-flop are all zero.
- R2: The source select uses 00 for the synchronized pin, 01 for the free-timer wrap pulse and 10 for the period-timer pulse. The code 11 gives a gate of 0 whatever the polarity.
- R3: The free timer advances by one on every tick. The tick that takes it from FFh to 00h makes its pulse high for exactly the next clock cycle.
- R4: The period timer advances on every tick until it equals the period input. The next tick clears it to 00h and makes its pulse high for exactly the next clock cycle.
- R5: With polarity 1 the selected source is used as it is. With polarity 0 it is inverted, so with the period source the counter advances on every tick except in the cycle after the reload.
- R6: In toggle mode (toggle input 1), the toggle flip-flop flips on every clock edge at which the polarity-adjusted gate is 1 and was 0 at the previous edge. The gate applied to the counter is the flip-flop output. The previous-gate register resets to 0.
- R7: While the toggle input is 0, the toggle flip-flop is cleared at every edge. After toggle mode is re-enabled, the flip-flop stays 0 until the next rising gate edge.
- R8: While the gate-enable input is 0, the gate applied is 1, so the counter advances on every tick.
- R9: The counter increases by one at each edge where the tick is 1 and the applied gate is 1. It wraps from FFFFh to 0000h, and the overflow output is then 1 for exactly the following cycle.
- R10: A load of 1 writes the load value at the next edge and takes priority over counting.
- R11: The external pin reaches the gate through two flops, so a change on the pin shows up on the gate status two edges later.
- R12: The gate status output always equals the gate currently applied to the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable for the counter and both helper timers |
| gate_en | input | 1 | 1 applies gating, 0 counts every tick |
| src_sel | input | 2 | Gate source: 00 pin, 01 free wrap, 10 period reload, 11 none |
| gate_pol | input | 1 | 1 active-high gate, 0 active-low gate |
| toggle_en | input | 1 | 1 routes the gate through the toggle flip-flop |
| gate_pin | input | 1 | Asynchronous external gate pin |
| period | input | 8 | Reload value of the period timer |
| load | input | 1 | Synchronous counter load |
| load_val | input | 16 | Value written by a load |
| count | output | 16 | Counter value |
| ovf | output | 1 | One-cycle wrap pulse of the counter |
| gate_val | output | 1 | Gate currently applied |

## Verification
The counter is driven with each gate source under both polarities. Over a fixed window, the period source gives one increment per reload when active high and all but one per reload when active low, which tells the polarity paths apart. The free-timer source gives one increment per 256 ticks, which separates it from the period path. Slow pin waveforms, in and out of toggle mode, expose the two-edge synchronizer latency and the whole-period measurement. A tick pattern with gaps shows whether the helper timers and the counter honour the tick, and loads near FFFFh cover the wrap and the priority of a load over counting.

// File: rtl/gtmr_pkg.sv
// Shared types of the gated timer: the encoding of the gate-source select.
package gtmr_pkg;
    typedef enum logic [1:0] {
        GSRC_PIN    = 2'b00,
        GSRC_T8WRAP = 2'b01,
        GSRC_PRLD   = 2'b10,
        GSRC_NONE   = 2'b11
    } gsrc_e;
endpackage

// File: rtl/gtmr_sync.sv
// Multi-flop synchronizer for the external gate pin.
// Assumes STAGES >= 2 and that the pin is a level, not a short pulse.
module gtmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    // Shift the pin through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/gtmr_free.sv
// Free-running W-bit timer that advances on tick. When it wraps from all-ones
// to zero it raises wrap_pulse for the following clock cycle.
// Assumes tick is synchronous to clk.
module gtmr_free #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic wrap_pulse
);
    localparam logic [W-1:0] ONE = W'(1);
    logic [W-1:0] cnt;

    // Advance the timer and record a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            wrap_pulse <= 1'b0;
        end else begin
            wrap_pulse <= tick && (cnt == '1);
            if (tick) cnt <= cnt + ONE;
        end
    end

    // R3
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |-> (cnt == '0));
    // R3
    wrap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |=> !wrap_pulse);
endmodule

// File: rtl/gtmr_period.sv
// W-bit period timer. It advances on tick until it equals the period value.
// The next tick clears it and raises rld_pulse for the following cycle.
// Assumes period changes only when the designer accepts one long cycle.
module gtmr_period #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] period,
    output logic         rld_pulse
);
    localparam logic [W-1:0] ONE = W'(1);
    logic [W-1:0] cnt;
    logic         hit;

    assign hit = (cnt == period);

    // Count towards the period and reload on the tick after a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            rld_pulse <= 1'b0;
        end else begin
            rld_pulse <= tick && hit;
            if (tick) cnt <= hit ? '0 : cnt + ONE;
        end
    end

    // R4
    rld_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rld_pulse |-> (cnt == '0));
endmodule

// File: rtl/gtmr_gate.sv
// Gate path: source multiplexer, polarity, toggle flip-flop and bypass.
// Produces the gate applied to the counter. Assumes all inputs are
// synchronous to clk.
module gtmr_gate
    import gtmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  gate_en,
    input  gsrc_e src,
    input  logic  gate_pol,
    input  logic  toggle_en,
    input  logic  pin_s,
    input  logic  wrap_pulse,
    input  logic  rld_pulse,
    output logic  gate_val
);
    logic raw;
    logic pol_g;
    logic prev_g;
    logic tff;
    logic rise;

    // Select the raw gate source.
    always_comb begin
        unique case (src)
            GSRC_PIN:    raw = pin_s;
            GSRC_T8WRAP: raw = wrap_pulse;
            GSRC_PRLD:   raw = rld_pulse;
            default:     raw = 1'b0;
        endcase
    end

    // Apply polarity; the reserved code stays inactive.
    always_comb begin
        if (src == GSRC_NONE) pol_g = 1'b0;
        else                  pol_g = gate_pol ? raw : ~raw;
    end

    assign rise = pol_g && !prev_g;

    // Track the previous gate and flip the toggle flop on rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_g <= 1'b0;
            tff    <= 1'b0;
        end else begin
            prev_g <= pol_g;
            if (!toggle_en) tff <= 1'b0;
            else if (rise)  tff <= ~tff;
        end
    end

    // Choose bypass, toggled or direct gate.
    always_comb begin
        if (!gate_en)      gate_val = 1'b1;
        else if (toggle_en) gate_val = tff;
        else               gate_val = pol_g;
    end

    // R6
    tff_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle_en && rise) |=> (tff != $past(tff)));
    // R7
    tff_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !toggle_en |=> !tff);
endmodule

// File: rtl/gated_timer.sv
// Top of the gated timer: a CNT_W-bit counter advanced on tick while the
// selected gate is active, plus helper timers, pin synchronizer and gate path.
// Assumes all inputs except gate_pin are synchronous to clk.
module gated_timer
    import gtmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int HELP_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              gate_en,
    input  logic [1:0]        src_sel,
    input  logic              gate_pol,
    input  logic              toggle_en,
    input  logic              gate_pin,
    input  logic [HELP_W-1:0] period,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  count,
    output logic              ovf,
    output logic              gate_val
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic pin_s;
    logic wrap_pulse;
    logic rld_pulse;
    logic adv;

    gtmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(gate_pin), .q(pin_s)
    );

    gtmr_free #(.W(HELP_W)) u_free (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wrap_pulse(wrap_pulse)
    );

    gtmr_period #(.W(HELP_W)) u_period (
        .clk(clk), .rst_n(rst_n), .tick(tick), .period(period),
        .rld_pulse(rld_pulse)
    );

    gtmr_gate u_gate (
        .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .src(gsrc_e'(src_sel)),
        .gate_pol(gate_pol), .toggle_en(toggle_en), .pin_s(pin_s),
        .wrap_pulse(wrap_pulse), .rld_pulse(rld_pulse), .gate_val(gate_val)
    );

    assign adv = tick && gate_val;

    // Load, count and flag a wrap of the main counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (load) begin
            count <= load_val;
            ovf   <= 1'b0;
        end else begin
            ovf <= adv && (count == '1);
            if (adv) count <= count + ONE;
        end
    end

    // R9
    ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (count == '0));
    // R10
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));
    // R8
    bypass_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_en && tick && !load) |=> (count == $past(count) + ONE));
    // R2
    rsvd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && !toggle_en && src_sel == 2'b11) |-> !gate_val);
endmodule

// File: tb/gated_timer_bench.sv
`timescale 1ns/1ps
module gated_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        gate_en = 1'b1;
    logic [1:0]  src_sel = 2'b00;
    logic        gate_pol = 1'b1;
    logic        toggle_en = 1'b0;
    logic        gate_pin = 1'b0;
    logic [7:0]  period = 8'd4;
    logic        load = 1'b0;
    logic [15:0] load_val = 16'h0;
    logic [15:0] count;
    logic        ovf;
    logic        gate_val;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    int m_cnt = 0, m_ovf = 0, m_free = 0, m_fp = 0, m_per = 0, m_pp = 0;
    int m_s1 = 0, m_s2 = 0, m_prev = 0, m_tff = 0;
    string phase = "R1";

    always #5 clk = ~clk;

    gated_timer u_gated_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .gate_en(gate_en),
        .src_sel(src_sel), .gate_pol(gate_pol), .toggle_en(toggle_en),
        .gate_pin(gate_pin), .period(period), .load(load),
        .load_val(load_val), .count(count), .ovf(ovf), .gate_val(gate_val)
    );

    function automatic int pol_gate();
        int raw;
        if (src_sel == 2'b11) return 0;
        raw = (src_sel == 2'b00) ? m_s2 : (src_sel == 2'b01) ? m_fp : m_pp;
        return gate_pol ? raw : 1 - raw;
    endfunction

    function automatic int exp_gate();
        if (!gate_en) return 1;
        if (toggle_en) return m_tff;
        return pol_gate();
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s (phase %s) act=%0h exp=%0h", req, phase, act, exp);
        end
    endtask

    // behavioural reference, updated at each edge from pre-edge values
    always @(posedge clk) begin
        int g, p, n_cnt, n_ovf, n_free, n_fp, n_per, n_pp, n_tff;
        if (!rst_n) begin
            m_cnt = 0; m_ovf = 0; m_free = 0; m_fp = 0; m_per = 0; m_pp = 0;
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_tff = 0;
        end else begin
            g = exp_gate();
            p = pol_gate();
            n_tff = !toggle_en ? 0 : ((p == 1 && m_prev == 0) ? 1 - m_tff : m_tff);
            n_ovf = 0;
            n_cnt = m_cnt;
            if (load) n_cnt = int'(load_val);
            else if (tick && g == 1) begin
                n_ovf = (m_cnt == 65535);
                n_cnt = (m_cnt + 1) % 65536;
            end
            n_fp = (tick && m_free == 255);
            n_free = tick ? (m_free + 1) % 256 : m_free;
            n_pp = (tick && m_per == int'(period));
            n_per = !tick ? m_per : (m_per == int'(period)) ? 0 : (m_per + 1) % 256;
            m_s2 = m_s1; m_s1 = gate_pin;
            m_prev = p; m_tff = n_tff; m_cnt = n_cnt; m_ovf = n_ovf;
            m_free = n_free; m_fp = n_fp; m_per = n_per; m_pp = n_pp;
        end
    end

    // compare every cycle away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(count) == m_cnt, "R9 count", count, m_cnt);
            chk(int'(ovf) == m_ovf, "R9 ovf", ovf, m_ovf);
            chk(int'(gate_val) == exp_gate(), "R12 gate_val", gate_val, exp_gate());
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int c0;
        cyc(3);
        @(negedge clk);
        // R1 reset state
        chk(count == 16'h0, "R1 count", count, 0);
        chk(ovf == 1'b0, "R1 ovf", ovf, 0);
        rst_n = 1'b1;
        cyc(1);

        // R8 bypass: every tick counts
        phase = "R8"; gate_en = 1'b0;
        @(negedge clk); c0 = count;
        cyc(10);
        @(negedge clk);
        chk(count == 16'(c0 + 10), "R8 bypass", count, c0 + 10);
        chk(gate_val == 1'b1, "R8 gate", gate_val, 1);

        // R4 period source, active high: one increment per 5 ticks
        phase = "R4"; gate_en = 1'b1; src_sel = 2'b10; gate_pol = 1'b1;
        @(negedge clk); c0 = count;
        cyc(50);
        @(negedge clk);
        chk(count == 16'(c0 + 10), "R4 period high", count, c0 + 10);

        // R5 active low: all but the reload cycle
        phase = "R5"; gate_pol = 1'b0;
        @(negedge clk); c0 = count;
        cyc(50);
        @(negedge clk);
        chk(count == 16'(c0 + 40), "R5 period low", count, c0 + 40);

        // R3 free-timer wrap source: one per 256 ticks
        phase = "R3"; src_sel = 2'b01; gate_pol = 1'b1;
        @(negedge clk); c0 = count;
        cyc(512);
        @(negedge clk);
        chk(count == 16'(c0 + 2), "R3 wrap rate", count, c0 + 2);
        gate_pol = 1'b0; cyc(300);

        // R2 reserved source under both polarities
        phase = "R2"; src_sel = 2'b11;
        @(negedge clk); c0 = count;
        chk(gate_val == 1'b0, "R2 reserved low pol", gate_val, 0);
        cyc(20); gate_pol = 1'b1; cyc(20);
        @(negedge clk);
        chk(count == 16'(c0), "R2 reserved hold", count, c0);

        // R11 pin latency
        phase = "R11"; src_sel = 2'b00; gate_pin = 1'b0; cyc(4);
        gate_pin = 1'b1;
        @(negedge clk); chk(gate_val == 1'b0, "R11 edge0", gate_val, 0);
        cyc(1); @(negedge clk); chk(gate_val == 1'b0, "R11 edge1", gate_val, 0);
        cyc(1); @(negedge clk); chk(gate_val == 1'b1, "R11 edge2", gate_val, 1);
        gate_pol = 1'b0; cyc(7); gate_pin = 1'b0; cyc(9); gate_pol = 1'b1;

        // R7 toggle re-enabled with pin held high stays clear
        phase = "R7"; gate_pin = 1'b1; cyc(5);
        toggle_en = 1'b1;
        @(negedge clk); chk(gate_val == 1'b0, "R7 cleared", gate_val, 0);
        cyc(5); @(negedge clk); chk(gate_val == 1'b0, "R7 held", gate_val, 0);

        // R6 rising edge flips the toggle flop after sync
        phase = "R6"; gate_pin = 1'b0; cyc(4);
        gate_pin = 1'b1; cyc(3);
        @(negedge clk); chk(gate_val == 1'b1, "R6 flip", gate_val, 1);
        for (int i = 0; i < 12; i++) begin gate_pin = ~gate_pin; cyc(6 + i); end
        toggle_en = 1'b0; cyc(3); toggle_en = 1'b1;
        for (int i = 0; i < 8; i++) begin gate_pin = ~gate_pin; cyc(5); end
        src_sel = 2'b10; period = 8'd2; cyc(60);
        gate_pol = 1'b0; cyc(40); toggle_en = 1'b0; gate_pol = 1'b1;

        // R4 period zero and tick gaps
        phase = "R4"; period = 8'd0; cyc(20);
        for (int i = 0; i < 90; i++) begin tick = (i % 3) != 0; cyc(1); end
        period = 8'd6;
        for (int i = 0; i < 90; i++) begin tick = (i % 4) != 1; cyc(1); end
        phase = "R3"; src_sel = 2'b01;
        for (int i = 0; i < 600; i++) begin tick = (i % 5) != 2; cyc(1); end
        tick = 1'b1;

        // R9 wrap and ovf pulse
        phase = "R9"; gate_en = 1'b0; load = 1'b1; load_val = 16'hFFFE; cyc(1);
        load = 1'b0;
        @(negedge clk); chk(count == 16'hFFFE, "R10 load", count, 16'hFFFE);
        cyc(2); @(negedge clk);
        chk(count == 16'h0000, "R9 wrap", count, 0);
        chk(ovf == 1'b1, "R9 ovf pulse", ovf, 1);
        cyc(1); @(negedge clk); chk(ovf == 1'b0, "R9 ovf single", ovf, 0);

        // R10 load priority over counting
        phase = "R10"; load = 1'b1; load_val = 16'h1234; cyc(2);
        @(negedge clk); chk(count == 16'h1234, "R10 priority", count, 16'h1234);
        load_val = 16'hFFFF; cyc(1); load = 1'b0; gate_en = 1'b1; src_sel = 2'b10;
        gate_pol = 1'b0; cyc(30);

        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule